// File: doc/BRIEF.md
# Intra 4x4 Block Pipeline Scheduler

This block orders the sixteen 4x4 luma blocks of one macroblock through two stages, prediction and reconstruction, so that the two stages overlap wherever the data allow. It issues one-cycle start pulses to each stage, tags each pulse with the scan position being worked on, and takes the one-cycle done pulses that come back. Prediction of the next position waits for reconstruction of the current one only when a dependency table marks that transition. Otherwise it starts as soon as the prediction stage is free, while the previous position reconstructs in parallel.

A macroblock is requested with a valid/ready handshake. When the last reconstruction finishes, the block pulses a results-valid flag and publishes the macroblock's cycle count. Four capture strobes mark the points where downstream logic should latch state. The dependency table is loaded one entry per write while the scheduler is idle, so a different scan order can be chosen between macroblocks. The stage datapaths are outside this block.

Top module: `blk_pipe_sched`

## Requirements
- R1: Each macroblock issues exactly 16 prediction starts and 16 reconstruction starts, with `pred_idx` and `rec_idx` counting up from 0 to 15. Reconstruction of a position starts in the cycle after its prediction done pulse, provided the reconstruction stage is free or finishes in that same cycle. Start pulses last one cycle.
- R2: If table entry k is 0, prediction of position k+1 starts in the cycle after the prediction done pulse of position k. With 13-cycle stages this gives a gap of 13 cycles between starts. If entry k is 1, prediction of position k+1 starts in the cycle after the reconstruction done pulse of position k, which gives a gap of 26 cycles.
- R3: Table entry k (k from 0 to 14) marks whether position k+1 depends on position k. Entry 15 has no effect. After reset the table marks entries 0, 1, 6, 13 and 14, value 16'h6043, and a macroblock then takes 286 cycles.
- R4: A write with `dep_we` high sets entry `dep_pos` to `dep_val` and takes effect for the next macroblock. Writes made while a macroblock is in progress are ignored.
- R5: `cyc_count` (10 bits) is loaded in the cycle `mb_done` pulses. It holds the count of cycles from the first prediction start through the final reconstruction done, both inclusive, and holds its value at all other times. Table 16'h6223 gives 299 cycles and table 16'h7FFF gives 416 cycles.
- R6: `mb_done` is high for exactly one cycle, the cycle after the reconstruction done pulse of position 15.
- R7: `mb_ready` is high only while idle. A request is accepted when `mb_valid` and `mb_ready` are both high. `mb_ready` falls in the next cycle and rises again in the cycle after `mb_done`. `mb_valid` has no effect while `mb_ready` is low.
- R8: `cap_stb[0]` pulses in the cycle after acceptance, one cycle before the first prediction start. `cap_stb[1]` pulses in the cycle after each prediction done pulse. `cap_stb[2]` pulses in the cycle after each reconstruction done pulse. `cap_stb[3]` pulses together with `mb_done`.
- R9: A synchronous active-high reset, applied at any time, returns the block to idle. Afterwards `mb_ready` is 1, all pulses are 0, `cyc_count` is 0 and the table holds 16'h6043.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mb_valid | input | 1 | Macroblock request |
| mb_ready | output | 1 | Idle and able to accept a request |
| dep_we | input | 1 | Dependency table write strobe |
| dep_pos | input | 4 | Table entry written |
| dep_val | input | 1 | Value written (1 = wait for reconstruction) |
| pred_start | output | 1 | Prediction stage start pulse |
| pred_idx | output | 4 | Scan position for the prediction stage |
| pred_done | input | 1 | Prediction stage done pulse |
| rec_start | output | 1 | Reconstruction stage start pulse |
| rec_idx | output | 4 | Scan position for the reconstruction stage |
| rec_done | input | 1 | Reconstruction stage done pulse |
| cap_stb | output | 4 | Capture strobes: accept, prediction result, reconstruction result, final result |
| mb_done | output | 1 | Macroblock results valid pulse |
| cyc_count | output | 10 | Cycle count of the last macroblock |

## Verification
The bench models each stage as a 13-cycle stub whose done pulse comes 12 cycles after the start pulse. From the loaded table it expects the next prediction start 13 or 26 cycles after the previous one, and each reconstruction start 13 cycles after the prediction start of the same position. `mb_done` and the new `cyc_count` are due in the cycle after the final reconstruction done, and `mb_ready` one cycle after that. The first prediction start is due one cycle after the accept strobe. The bench drives inputs and samples outputs on the falling clock edge, so each check reads the registered value of the cycle it targets. Event counts are read only after the monitor has settled.

// File: rtl/blk_sched_pkg.sv
package blk_sched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FLAG = 2'd2
  } sched_st_e;

  // capture strobe bit positions
  localparam int unsigned STB_ACCEPT = 0;
  localparam int unsigned STB_PRED   = 1;
  localparam int unsigned STB_REC    = 2;
  localparam int unsigned STB_FINAL  = 3;
  localparam int unsigned STB_NUM    = 4;

endpackage

// File: rtl/blk_dep_table.sv
module blk_dep_table #(
  parameter int unsigned NBLK = 16,
  parameter int unsigned POS_W = $clog2(NBLK),
  parameter logic [NBLK-1:0] DEP_INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [POS_W-1:0] wr_pos_i,
  input  logic             wr_val_i,
  input  logic             lock_i,
  output logic [NBLK-1:0]  dep_vec_o
);

  // one flop per scan position; the scheduler reads any entry in the same cycle
  for (genvar k = 0; k < NBLK; k++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        dep_vec_o[k] <= DEP_INIT[k];
      end else if (wr_en_i && !lock_i && (wr_pos_i == POS_W'(k))) begin
        dep_vec_o[k] <= wr_val_i;
      end
    end
  end

endmodule

// File: rtl/blk_issue_ctl.sv
module blk_issue_ctl
  import blk_sched_pkg::*;
#(
  parameter int unsigned NBLK = 16,
  parameter int unsigned POS_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mb_valid_i,
  output logic             mb_ready_o,
  input  logic [NBLK-1:0]  dep_vec_i,
  input  logic             pred_done_i,
  input  logic             rec_done_i,
  output logic             pred_start_o,
  output logic [POS_W-1:0] pred_idx_o,
  output logic             rec_start_o,
  output logic [POS_W-1:0] rec_idx_o,
  output logic             mb_done_o,
  output logic             busy_o,
  output logic             acc_ev_o,
  output logic             pd_ev_o,
  output logic             rd_ev_o,
  output logic             fin_ev_o
);

  localparam int unsigned NXT_W = POS_W + 1;

  sched_st_e          st_q;
  logic [NXT_W-1:0]   nxt_q;      // next scan position to predict
  logic [NXT_W-1:0]   rdone_q;    // reconstructions finished so far
  logic               pbusy_q;
  logic               rbusy_q;
  logic               res_q;      // prediction result waiting for reconstruction
  logic [POS_W-1:0]   res_pos_q;

  logic               run;
  logic               have_res;
  logic [POS_W-1:0]   src_pos;
  logic               rec_free;
  logic               rec_go;
  logic [NXT_W-1:0]   rdone_now;
  logic [POS_W-1:0]   prev_pos;
  logic               dep_ok;
  logic               slot_ok;
  logic               pred_go;

  always_comb begin
    run       = (st_q == ST_RUN);
    acc_ev_o  = (st_q == ST_IDLE) && mb_ready_o && mb_valid_i;
    pd_ev_o   = run && pbusy_q && pred_done_i;
    rd_ev_o   = run && rbusy_q && rec_done_i;
    fin_ev_o  = rd_ev_o && (rec_idx_o == POS_W'(NBLK - 1));
    have_res  = res_q || pd_ev_o;
    src_pos   = res_q ? res_pos_q : pred_idx_o;
    rec_free  = !rbusy_q || rd_ev_o;
    rec_go    = run && have_res && rec_free;
    rdone_now = rdone_q + NXT_W'(rd_ev_o);
    prev_pos  = POS_W'(nxt_q - NXT_W'(1));
    // a marked transition waits until the previous position is reconstructed
    dep_ok    = (nxt_q == '0) || !dep_vec_i[prev_pos] || (rdone_now >= nxt_q);
    // the single result holding slot must be free after this edge
    slot_ok   = !(have_res && !rec_go);
    pred_go   = run && (!pbusy_q || pd_ev_o) && (nxt_q < NXT_W'(NBLK)) && dep_ok && slot_ok;
    busy_o    = (st_q != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      mb_ready_o   <= 1'b1;
      mb_done_o    <= 1'b0;
      pred_start_o <= 1'b0;
      rec_start_o  <= 1'b0;
      pred_idx_o   <= '0;
      rec_idx_o    <= '0;
      nxt_q        <= '0;
      rdone_q      <= '0;
      pbusy_q      <= 1'b0;
      rbusy_q      <= 1'b0;
      res_q        <= 1'b0;
      res_pos_q    <= '0;
    end else begin
      pred_start_o <= pred_go;
      rec_start_o  <= rec_go;
      mb_done_o    <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (acc_ev_o) begin
            st_q       <= ST_RUN;
            mb_ready_o <= 1'b0;
            nxt_q      <= '0;
            rdone_q    <= '0;
            pbusy_q    <= 1'b0;
            rbusy_q    <= 1'b0;
            res_q      <= 1'b0;
          end
        end
        ST_RUN: begin
          if (pred_go) begin
            pred_idx_o <= nxt_q[POS_W-1:0];
            nxt_q      <= nxt_q + NXT_W'(1);
          end
          pbusy_q <= pred_go || (pbusy_q && !pd_ev_o);
          if (rec_go) begin
            rec_idx_o <= src_pos;
          end
          rbusy_q <= rec_go || (rbusy_q && !rd_ev_o);
          res_q   <= have_res && !rec_go;
          if (pd_ev_o) begin
            res_pos_q <= pred_idx_o;
          end
          rdone_q <= rdone_now;
          if (fin_ev_o) begin
            st_q      <= ST_FLAG;
            mb_done_o <= 1'b1;
          end
        end
        default: begin
          st_q       <= ST_IDLE;
          mb_ready_o <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/blk_cycle_meter.sv
module blk_cycle_meter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first_i,
  input  logic             finish_i,
  output logic [CNT_W-1:0] cyc_count_o
);

  logic             run_q;
  logic [CNT_W-1:0] acc_q;

  // acc_q equals the inclusive number of cycles since the first start
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= 1'b0;
      acc_q       <= '0;
      cyc_count_o <= '0;
    end else begin
      if (first_i) begin
        run_q <= 1'b1;
        acc_q <= CNT_W'(2);
      end else if (run_q && (acc_q != '1)) begin
        acc_q <= acc_q + CNT_W'(1);
      end
      if (finish_i && run_q) begin
        cyc_count_o <= acc_q;
        run_q       <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/blk_strobe_gen.sv
module blk_strobe_gen #(
  parameter int unsigned NSTB = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSTB-1:0] ev_i,
  output logic [NSTB-1:0] stb_o
);

  for (genvar b = 0; b < NSTB; b++) begin : g_stb
    always_ff @(posedge clk) begin
      if (rst) begin
        stb_o[b] <= 1'b0;
      end else begin
        stb_o[b] <= ev_i[b];
      end
    end
  end

endmodule

// File: rtl/blk_pipe_sched.sv
module blk_pipe_sched
  import blk_sched_pkg::*;
#(
  parameter int unsigned NBLK = 16,
  parameter int unsigned CNT_W = 10,
  parameter int unsigned POS_W = $clog2(NBLK),
  parameter logic [NBLK-1:0] DEP_INIT = 16'h6043
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mb_valid,
  output logic               mb_ready,
  input  logic               dep_we,
  input  logic [POS_W-1:0]   dep_pos,
  input  logic               dep_val,
  output logic               pred_start,
  output logic [POS_W-1:0]   pred_idx,
  input  logic               pred_done,
  output logic               rec_start,
  output logic [POS_W-1:0]   rec_idx,
  input  logic               rec_done,
  output logic [STB_NUM-1:0] cap_stb,
  output logic               mb_done,
  output logic [CNT_W-1:0]   cyc_count
);

  logic [NBLK-1:0]    dep_vec;
  logic               busy;
  logic               acc_ev;
  logic               pd_ev;
  logic               rd_ev;
  logic               fin_ev;
  logic               first_start;
  logic [STB_NUM-1:0] stb_ev;

  blk_dep_table #(
    .NBLK(NBLK), .POS_W(POS_W), .DEP_INIT(DEP_INIT)
  ) u_table (
    .clk(clk), .rst(rst),
    .wr_en_i(dep_we), .wr_pos_i(dep_pos), .wr_val_i(dep_val),
    .lock_i(busy), .dep_vec_o(dep_vec)
  );

  blk_issue_ctl #(
    .NBLK(NBLK), .POS_W(POS_W)
  ) u_issue (
    .clk(clk), .rst(rst),
    .mb_valid_i(mb_valid), .mb_ready_o(mb_ready),
    .dep_vec_i(dep_vec),
    .pred_done_i(pred_done), .rec_done_i(rec_done),
    .pred_start_o(pred_start), .pred_idx_o(pred_idx),
    .rec_start_o(rec_start), .rec_idx_o(rec_idx),
    .mb_done_o(mb_done), .busy_o(busy),
    .acc_ev_o(acc_ev), .pd_ev_o(pd_ev), .rd_ev_o(rd_ev), .fin_ev_o(fin_ev)
  );

  assign first_start = pred_start && (pred_idx == '0);

  blk_cycle_meter #(
    .CNT_W(CNT_W)
  ) u_meter (
    .clk(clk), .rst(rst),
    .first_i(first_start), .finish_i(fin_ev),
    .cyc_count_o(cyc_count)
  );

  always_comb begin
    stb_ev             = '0;
    stb_ev[STB_ACCEPT] = acc_ev;
    stb_ev[STB_PRED]   = pd_ev;
    stb_ev[STB_REC]    = rd_ev;
    stb_ev[STB_FINAL]  = fin_ev;
  end

  blk_strobe_gen #(
    .NSTB(STB_NUM)
  ) u_stb (
    .clk(clk), .rst(rst), .ev_i(stb_ev), .stb_o(cap_stb)
  );

endmodule

// File: rtl/blk_pipe_sched_chk.sv
module blk_pipe_sched_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             mb_valid,
  input logic             mb_ready,
  input logic             pred_start,
  input logic             rec_start,
  input logic             mb_done,
  input logic             final_stb,
  input logic [CNT_W-1:0] cyc_count
);

  // R6
  mb_done_single_chk: assert property (@(posedge clk) disable iff (rst)
    mb_done |=> !mb_done);

  // R7
  accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mb_valid && mb_ready) |=> !mb_ready);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mb_ready |-> !(pred_start || rec_start));

  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pred_start |=> !pred_start);

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mb_done |-> $stable(cyc_count));

  // R8
  final_stb_chk: assert property (@(posedge clk) disable iff (rst)
    final_stb |-> mb_done);

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (mb_ready && !mb_done));

endmodule

bind blk_pipe_sched blk_pipe_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mb_valid(mb_valid), .mb_ready(mb_ready),
  .pred_start(pred_start), .rec_start(rec_start), .mb_done(mb_done),
  .final_stb(cap_stb[3]), .cyc_count(cyc_count)
);

// File: tb/blk_pipe_sched_bench.sv
module blk_pipe_sched_bench;

  localparam int NBLK  = 16;
  localparam int CNT_W = 10;
  localparam int POS_W = 4;
  localparam int LAT   = 13;
  localparam int NROW  = 6;

  typedef struct packed {
    logic [15:0] dep;
    logic [15:0] exp;
  } row_t;

  // table contents and the macroblock cycle count each one must give
  localparam row_t ROWS [NROW] = '{
    '{16'h6043, 16'd286},
    '{16'h6223, 16'd299},
    '{16'h7FFF, 16'd416},
    '{16'h0000, 16'd221},
    '{16'h0080, 16'd234},
    '{16'h8000, 16'd221}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mb_valid = 1'b0;
  logic             mb_ready;
  logic             dep_we = 1'b0;
  logic [POS_W-1:0] dep_pos = '0;
  logic             dep_val = 1'b0;
  logic             pred_start;
  logic [POS_W-1:0] pred_idx;
  logic             pred_done;
  logic             rec_start;
  logic [POS_W-1:0] rec_idx;
  logic             rec_done;
  logic [3:0]       cap_stb;
  logic             mb_done;
  logic [CNT_W-1:0] cyc_count;

  always #5 clk = ~clk;

  blk_pipe_sched u_blk_pipe_sched (
    .clk(clk), .rst(rst), .mb_valid(mb_valid), .mb_ready(mb_ready),
    .dep_we(dep_we), .dep_pos(dep_pos), .dep_val(dep_val),
    .pred_start(pred_start), .pred_idx(pred_idx), .pred_done(pred_done),
    .rec_start(rec_start), .rec_idx(rec_idx), .rec_done(rec_done),
    .cap_stb(cap_stb), .mb_done(mb_done), .cyc_count(cyc_count)
  );

  // fixed-latency stage stubs: done pulse LAT-1 cycles after start
  int pcnt = 0;
  int rcnt = 0;
  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= 0;
      rcnt <= 0;
    end else begin
      if (pred_start) pcnt <= LAT - 1;
      else if (pcnt > 0) pcnt <= pcnt - 1;
      if (rec_start) rcnt <= LAT - 1;
      else if (rcnt > 0) rcnt <= rcnt - 1;
    end
  end
  assign pred_done = (pcnt == 1);
  assign rec_done  = (rcnt == 1);

  // event monitor
  int  cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic mon_clr = 1'b0;
  int pst [NBLK];
  int rct [NBLK];
  int n_pred = 0, n_rec = 0, pidx_bad = 0, ridx_bad = 0;
  int n_s0 = 0, n_s1 = 0, n_s2 = 0, n_s3 = 0, s0_t = 0;

  always @(negedge clk) begin
    if (mon_clr) begin
      n_pred = 0; n_rec = 0; pidx_bad = 0; ridx_bad = 0;
      n_s0 = 0; n_s1 = 0; n_s2 = 0; n_s3 = 0;
    end else begin
      if (pred_start) begin
        if (n_pred < NBLK) pst[n_pred] = cyc;
        if (int'(pred_idx) != n_pred) pidx_bad++;
        n_pred++;
      end
      if (rec_start) begin
        if (n_rec < NBLK) rct[n_rec] = cyc;
        if (int'(rec_idx) != n_rec) ridx_bad++;
        n_rec++;
      end
      if (cap_stb[0]) begin n_s0++; s0_t = cyc; end
      if (cap_stb[1]) n_s1++;
      if (cap_stb[2]) n_s2++;
      if (cap_stb[3]) n_s3++;
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_table(input logic [15:0] vec);
    for (int k = 0; k < NBLK; k++) begin
      @(negedge clk);
      dep_we = 1'b1; dep_pos = POS_W'(k); dep_val = vec[k];
    end
    @(negedge clk);
    dep_we = 1'b0;
  endtask

  task automatic run_mb(input logic [15:0] dep, input int exp, input bit poke_start,
                        input bit poke_tbl);
    int t;
    int gap_bad;
    int rec_bad;
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
    for (int i = 0; i < 100 && !mb_ready; i++) @(negedge clk);
    mb_valid = 1'b1;
    @(negedge clk);
    mb_valid = 1'b0;
    t = 0;
    while (!mb_done && t < 2000) begin
      mb_valid = poke_start && (t == 40);
      dep_we   = poke_tbl && (t == 60);
      dep_pos  = POS_W'(3);
      dep_val  = ~dep[3];
      @(negedge clk);
      t++;
    end
    mb_valid = 1'b0;
    dep_we = 1'b0;
    chk("R6 mb_done seen", int'(mb_done), 1);
    chk("R5 cyc_count", int'(cyc_count), exp);
    chk("R7 ready low at done", int'(mb_ready), 0);
    @(negedge clk);
    chk("R6 mb_done one cycle", int'(mb_done), 0);
    chk("R7 ready back after done", int'(mb_ready), 1);
    repeat (20) @(negedge clk);
    chk("R1 prediction starts", n_pred, NBLK);
    chk("R1 reconstruction starts", n_rec, NBLK);
    chk("R1 index order", pidx_bad + ridx_bad, 0);
    gap_bad = 0;
    rec_bad = 0;
    for (int n = 0; n < NBLK; n++) begin
      if (rct[n] - pst[n] != LAT) rec_bad++;
      if (n < NBLK - 1) begin
        if (pst[n+1] - pst[n] != (dep[n] ? 2 * LAT : LAT)) gap_bad++;
      end
    end
    chk("R2 prediction start gaps", gap_bad, 0);
    chk("R1 rec start after pred", rec_bad, 0);
    chk("R8 accept strobe count", n_s0, 1);
    chk("R8 accept strobe lead", pst[0] - s0_t, 1);
    chk("R8 pred strobe count", n_s1, NBLK);
    chk("R8 rec strobe count", n_s2, NBLK);
    chk("R8 final strobe count", n_s3, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 ready after reset", int'(mb_ready), 1);
    chk("R9 done after reset", int'(mb_done), 0);
    chk("R9 count after reset", int'(cyc_count), 0);
    chk("R9 strobes after reset", int'(cap_stb), 0);
    chk("R9 starts after reset", int'(pred_start) + int'(rec_start), 0);

    // R3 reset table gives 286
    run_mb(16'h6043, 286, 1'b0, 1'b0);

    // table walk: R3 R5 R2
    for (int r = 0; r < NROW; r++) begin
      load_table(ROWS[r].dep);
      run_mb(ROWS[r].dep, int'(ROWS[r].exp), 1'b0, 1'b0);
    end

    // R7 start ignored while busy, R4 write ignored while busy
    load_table(16'h6223);
    run_mb(16'h6223, 299, 1'b1, 1'b1);
    run_mb(16'h6223, 299, 1'b0, 1'b0);

    // R9 reset in the middle of a macroblock restores idle and default table
    @(negedge clk);
    mb_valid = 1'b1;
    @(negedge clk);
    mb_valid = 1'b0;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 ready after mid reset", int'(mb_ready), 1);
    chk("R9 count after mid reset", int'(cyc_count), 0);
    repeat (20) @(negedge clk);
    chk("R9 quiet after mid reset", int'(pred_start) + int'(rec_start), 0);
    run_mb(16'h6043, 286, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end

endmodule